// File: doc/BRIEF.md
# Posted-Write PCI Memory Target

This block is a bus-side target for 32-bit PCI memory space. It watches each address phase, and it claims a transaction only when the command is a memory read or a memory write and the address falls inside a fixed base/size window. It claims with medium decode timing. After a claim it drives DEVSEL#, TRDY#, and during reads also AD and PAR. The AD, PAR and control lines are given as separate value and enable outputs, so the pad ring can build the tri-state drivers.

Writes are always posted. Each completed write data phase goes as one entry into a small FIFO, and an application-side consumer empties that FIFO one entry per cycle through a valid/ready port. TRDY# is withdrawn only while the FIFO is full.

Reads wait through an initial target latency before the first TRDY#. That latency is taken from a 4-bit input plus a region-select bit that adds extra cycles. It stands in for the fetch time and the domain-crossing time on the application side. Read data comes from an application port addressed by the target. Even parity for each read data cycle goes out on PAR one clock later.

Top module: `pciMemTarget`

## Requirements
- R1: While reset is held and after its release, devselN and trdyN are high, and ctlOe, adOe, parOe and drnValid are low.
- R2: A transaction is claimed when C/BE# carries 0x6 (memory read) or 0x7 (memory write) in the address phase and AD[31:12] equals the window base. devselN stays high in the cycle after the address phase and is low in the second cycle after it.
- R3: Any other command, or an address outside the window, is ignored. devselN, trdyN and ctlOe stay inactive, no FIFO entry appears, and a following claimed transaction still behaves normally.
- R4: For a write into an empty FIFO, trdyN is first low in the third cycle after the address phase.
- R5: Each completed write data phase (irdyN and trdyN both low) gives one FIFO entry, in order. The entry holds the phase address (start address with bits [1:0] cleared, plus 4 per earlier phase), the AD data, and active-high byte enables equal to the inverse of C/BE#.
- R6: The FIFO holds 8 entries. With the drain stalled, 8 phases complete in consecutive cycles and trdyN then stays high. trdyN is low again in the cycle after the first pop.
- R7: For a read, trdyN is first low in cycle L after the address phase. L = latIn + (regionSel ? 2 : 0), with a minimum of 3.
- R8: In every read cycle with trdyN low, adOe is high and adOut equals rdData. rdAddr holds the phase address, which advances by 4 per completed phase.
- R9: parOe is high in the cycle after each cycle with adOe high. In that cycle parOut is the even parity (XOR) of the previous cycle's adOut and cbeN.
- R10: After the data phase that completes with frameN high, devselN and trdyN are driven high for one cycle with ctlOe high. ctlOe is low in the following cycle.
- R11: The drain port pops one entry in each cycle where drnValid and drnReady are both high. drnValid is high whenever the FIFO is not empty, and the entry is held stable while drnReady is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset |
| frameN | input | 1 | FRAME# from the master |
| irdyN | input | 1 | IRDY# from the master |
| adIn | input | 32 | Address/data bus as received |
| cbeN | input | 4 | Command / byte enables, active low |
| adOut | output | 32 | Read data to drive on AD |
| adOe | output | 1 | AD output enable |
| parOut | output | 1 | Even parity to drive on PAR |
| parOe | output | 1 | PAR output enable |
| devselN | output | 1 | DEVSEL# value |
| trdyN | output | 1 | TRDY# value |
| ctlOe | output | 1 | Enable for DEVSEL# and TRDY# drivers |
| latIn | input | 4 | Base read latency in clocks |
| regionSel | input | 1 | Selects the slower read region (+2 clocks) |
| rdAddr | output | 32 | Address of the current read phase |
| rdData | input | 32 | Read data returned for rdAddr |
| drnValid | output | 1 | FIFO has an entry to drain |
| drnReady | input | 1 | Consumer accepts an entry this cycle |
| drnAddr | output | 32 | Address of the head entry |
| drnData | output | 32 | Data of the head entry |
| drnBe | output | 4 | Active-high byte enables of the head entry |

## Verification
If the control state machine is in the wrong state, the claim timing is wrong at once. DEVSEL# or TRDY# shifts by a cycle or more against the address phase, and the check at cycle 2, at cycle 3 or at cycle L catches it within that transaction. A wrong FIFO count or pointer shows in one of two ways: TRDY# is throttled at the wrong burst beat, or the drain port gives a missing, repeated or reordered entry. The scoreboard catches the drain error on the first bad pop. A wrong read address or parity register shows on AD in the same cycle or on PAR one cycle later.

// File: rtl/pciTgtPkg.sv
package pciTgtPkg;
  localparam int AD_W = 32;
  localparam int BE_W = 4;
  localparam logic [BE_W-1:0] CMD_MEM_RD = 4'h6;
  localparam logic [BE_W-1:0] CMD_MEM_WR = 4'h7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEC, ST_WAIT, ST_DATA, ST_TURN, ST_SKIP
  } tgtState_t;

  typedef struct packed {
    logic loadAddr;
    logic advance;
    logic pushWr;
    logic driveRd;
  } tgtStrobe_t;
endpackage

// File: rtl/tgtControl.sv
module tgtControl
  import pciTgtPkg::*;
#(
  parameter logic [AD_W-1:0] BASE_ADDR    = 32'h4000_0000,
  parameter int              WIN_BITS     = 12,
  parameter int              LAT_W        = 4,
  parameter int              REGION_EXTRA = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic [AD_W-1:0]  adIn,
  input  logic [BE_W-1:0]  cbeN,
  input  logic [LAT_W-1:0] latIn,
  input  logic             regionSel,
  input  logic             fifoFull,
  output tgtStrobe_t       strobe,
  output logic             devselN,
  output logic             trdyN,
  output logic             ctlOe
);
  localparam int CNT_W   = LAT_W + 2;
  localparam int MIN_LAT = 3;

  tgtState_t        state, stateNext;
  logic             isWrite;
  logic [CNT_W-1:0] waitCnt;
  logic             cmdOk, addrOk, claim;
  logic [CNT_W-1:0] totalLat;

  assign cmdOk    = (cbeN == CMD_MEM_RD) || (cbeN == CMD_MEM_WR);
  assign addrOk   = adIn[AD_W-1:WIN_BITS] == BASE_ADDR[AD_W-1:WIN_BITS];
  assign claim    = cmdOk && addrOk;
  assign totalLat = CNT_W'(latIn) + (regionSel ? CNT_W'(REGION_EXTRA) : '0);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (!frameN) stateNext = claim ? ST_DEC : ST_SKIP;
      ST_DEC:  stateNext = ST_WAIT;
      ST_WAIT: if (waitCnt == '0) stateNext = ST_DATA;
      ST_DATA: if (strobe.advance && frameN) stateNext = ST_TURN;
      ST_TURN: stateNext = ST_IDLE;
      ST_SKIP: if (frameN && irdyN) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isWrite <= 1'b0;
      waitCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.loadAddr) isWrite <= (cbeN == CMD_MEM_WR);
      if (state == ST_DEC) begin
        if (isWrite || totalLat <= CNT_W'(MIN_LAT)) waitCnt <= '0;
        else waitCnt <= totalLat - CNT_W'(MIN_LAT);
      end else if (state == ST_WAIT && waitCnt != '0) begin
        waitCnt <= waitCnt - 1'b1;
      end
    end
  end

  assign trdyN   = !(state == ST_DATA && (!isWrite || !fifoFull));
  assign devselN = !(state == ST_WAIT || state == ST_DATA);
  assign ctlOe   = (state == ST_WAIT) || (state == ST_DATA) || (state == ST_TURN);

  assign strobe.loadAddr = (state == ST_IDLE) && !frameN && claim;
  assign strobe.advance  = (state == ST_DATA) && !irdyN && !trdyN;
  assign strobe.pushWr   = strobe.advance && isWrite;
  assign strobe.driveRd  = (state == ST_DATA) && !isWrite;
endmodule

// File: rtl/tgtDatapath.sv
module tgtDatapath
  import pciTgtPkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  tgtStrobe_t      strobe,
  input  logic [AD_W-1:0] adIn,
  input  logic [BE_W-1:0] cbeN,
  input  logic [AD_W-1:0] rdData,
  input  logic            drnReady,
  output logic [AD_W-1:0] rdAddr,
  output logic [AD_W-1:0] adOut,
  output logic            adOe,
  output logic            parOut,
  output logic            parOe,
  output logic            fifoFull,
  output logic            drnValid,
  output logic [AD_W-1:0] drnAddr,
  output logic [AD_W-1:0] drnData,
  output logic [BE_W-1:0] drnBe
);
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int ENTRY_W = 2 * AD_W + BE_W;

  logic [AD_W-1:0]    curAddr;
  logic [ENTRY_W-1:0] fifoMem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count;
  logic               pop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curAddr <= '0;
    else if (strobe.loadAddr) curAddr <= {adIn[AD_W-1:2], 2'b00};
    else if (strobe.advance) curAddr <= curAddr + AD_W'(4);
  end

  assign pop      = drnValid && drnReady;
  assign fifoFull = count == CNT_W'(DEPTH);
  assign drnValid = count != '0;

  always_ff @(posedge clk) begin
    if (strobe.pushWr) fifoMem[wrPtr] <= {curAddr, adIn, ~cbeN};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.pushWr) wrPtr <= nextPtr(wrPtr);
      if (pop) rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(strobe.pushWr) - CNT_W'(pop);
    end
  end

  assign {drnAddr, drnData, drnBe} = fifoMem[rdPtr];

  assign rdAddr = curAddr;
  assign adOe   = strobe.driveRd;
  assign adOut  = strobe.driveRd ? rdData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parOut <= 1'b0;
      parOe  <= 1'b0;
    end else begin
      parOut <= ^{adOut, cbeN};
      parOe  <= adOe;
    end
  end
endmodule

// File: rtl/pciMemTarget.sv
module pciMemTarget
  import pciTgtPkg::*;
#(
  parameter logic [31:0] BASE_ADDR    = 32'h4000_0000,
  parameter int          WIN_BITS     = 12,
  parameter int          FIFO_DEPTH   = 8,
  parameter int          LAT_W        = 4,
  parameter int          REGION_EXTRA = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic             irdyN,
  input  logic [31:0]      adIn,
  input  logic [3:0]       cbeN,
  output logic [31:0]      adOut,
  output logic             adOe,
  output logic             parOut,
  output logic             parOe,
  output logic             devselN,
  output logic             trdyN,
  output logic             ctlOe,
  input  logic [LAT_W-1:0] latIn,
  input  logic             regionSel,
  output logic [31:0]      rdAddr,
  input  logic [31:0]      rdData,
  output logic             drnValid,
  input  logic             drnReady,
  output logic [31:0]      drnAddr,
  output logic [31:0]      drnData,
  output logic [3:0]       drnBe
);
  tgtStrobe_t strobe;
  logic       fifoFull;

  tgtControl #(
    .BASE_ADDR(BASE_ADDR), .WIN_BITS(WIN_BITS),
    .LAT_W(LAT_W), .REGION_EXTRA(REGION_EXTRA)
  ) i_control (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN),
    .adIn(adIn), .cbeN(cbeN), .latIn(latIn), .regionSel(regionSel),
    .fifoFull(fifoFull), .strobe(strobe),
    .devselN(devselN), .trdyN(trdyN), .ctlOe(ctlOe)
  );

  tgtDatapath #(.DEPTH(FIFO_DEPTH)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .adIn(adIn), .cbeN(cbeN),
    .rdData(rdData), .drnReady(drnReady), .rdAddr(rdAddr),
    .adOut(adOut), .adOe(adOe), .parOut(parOut), .parOe(parOe),
    .fifoFull(fifoFull), .drnValid(drnValid), .drnAddr(drnAddr),
    .drnData(drnData), .drnBe(drnBe)
  );
endmodule

// File: rtl/pciMemTargetChecker.sv
module pciMemTargetChecker #(
  parameter int DEPTH = 8
) (
  input logic        clk,
  input logic        rstN,
  input logic        frameN,
  input logic        irdyN,
  input logic [3:0]  cbeN,
  input logic [31:0] adOut,
  input logic        adOe,
  input logic        parOut,
  input logic        parOe,
  input logic        devselN,
  input logic        trdyN,
  input logic        ctlOe,
  input logic        drnValid,
  input logic        drnReady,
  input logic [31:0] drnData
);
  localparam int OCC_W = $clog2(DEPTH + 1) + 1;

  logic [OCC_W-1:0] occ;
  logic             wrBeat, popBeat;

  assign wrBeat  = !irdyN && !trdyN && !adOe;
  assign popBeat = drnValid && drnReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occ <= '0;
    else occ <= occ + OCC_W'(wrBeat) - OCC_W'(popBeat);
  end

  // R1: idle outputs after reset
  always_ff @(posedge clk) begin
    if (!rstN) assert_reset_idle_R1: assert (devselN && trdyN && !ctlOe && !adOe);
  end

  assert_devsel_medium_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(devselN) |-> !$past(frameN, 2));

  assert_trdy_claimed_R4: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> !devselN && ctlOe);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_W'(DEPTH));

  assert_full_throttle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (occ == OCC_W'(DEPTH)) |-> trdyN);

  assert_parity_R9: assert property (@(posedge clk) disable iff (!rstN)
    parOe |-> (parOut == ^{$past(adOut), $past(cbeN)}));

  assert_turn_drive_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(devselN) |-> ctlOe && trdyN);

  assert_hold_head_R11: assert property (@(posedge clk) disable iff (!rstN)
    drnValid && !drnReady |=> drnValid && $stable(drnData));
endmodule

bind pciMemTarget pciMemTargetChecker #(.DEPTH(FIFO_DEPTH)) i_checker (
  .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .cbeN(cbeN),
  .adOut(adOut), .adOe(adOe), .parOut(parOut), .parOe(parOe),
  .devselN(devselN), .trdyN(trdyN), .ctlOe(ctlOe),
  .drnValid(drnValid), .drnReady(drnReady), .drnData(drnData)
);

// File: tb/test_pciMemTarget.sv
`timescale 1ns/100ps
module test_pciMemTarget;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1, irdyN = 1'b1;
  logic [31:0] adIn = '0;
  logic [3:0]  cbeN = 4'hF;
  logic [31:0] adOut, rdAddr, rdData, drnAddr, drnData;
  logic        adOe, parOut, parOe, devselN, trdyN, ctlOe, drnValid;
  logic [3:0]  latIn = 4'd10, drnBe;
  logic        regionSel = 1'b0, drnReady = 1'b1;

  int nChecks = 0, nFails = 0, nPops = 0, nPushes = 0;
  logic [67:0] sbQueue [$];

  always #2.5 clk = ~clk;

  function automatic logic [31:0] rdModel(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction
  assign rdData = rdModel(rdAddr);

  pciMemTarget i_pciMemTarget (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .adIn(adIn),
    .cbeN(cbeN), .adOut(adOut), .adOe(adOe), .parOut(parOut), .parOe(parOe),
    .devselN(devselN), .trdyN(trdyN), .ctlOe(ctlOe), .latIn(latIn),
    .regionSel(regionSel), .rdAddr(rdAddr), .rdData(rdData),
    .drnValid(drnValid), .drnReady(drnReady), .drnAddr(drnAddr),
    .drnData(drnData), .drnBe(drnBe)
  );

  task automatic check(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares every pop with the oldest expected entry
  always @(negedge clk) begin
    #1;
    if (rstN && drnValid && drnReady) begin
      nPops++;
      if (sbQueue.size() == 0) check(1'b0, "R5 unexpected pop", {drnAddr, drnData, drnBe}, '0);
      else begin
        logic [67:0] e;
        e = sbQueue.pop_front();
        check({drnAddr, drnData, drnBe} == e, "R5/R11 drained entry", {drnAddr, drnData, drnBe}, e);
      end
    end
  end

  task automatic finishAddr();
    @(negedge clk); frameN = 1'b1; irdyN = 1'b1; adIn = '0; cbeN = 4'hF; drnReady = 1'b1;
    #0.5;
    check(devselN && trdyN && ctlOe, "R10 turnaround drive", {devselN, trdyN, ctlOe}, 3'b111);
    @(negedge clk); #0.5;
    check(!ctlOe && devselN, "R10 release", {ctlOe, devselN}, 2'b01);
  endtask

  task automatic doWrite(input logic [31:0] addr, input int n, input int releaseCyc);
    int cyc = 0, i = 0, firstTrdy = -1, guard = 0;
    logic [31:0] d;
    logic [3:0] be;
    @(negedge clk);
    frameN = 1'b0; irdyN = 1'b1; adIn = addr; cbeN = 4'h7; drnReady = (releaseCyc == 0);
    while (i < n && guard < 200) begin
      @(negedge clk); cyc++; guard++;
      drnReady = (cyc >= releaseCyc);
      d = addr ^ (32'h1111_0000 * (i + 1)) ^ 32'(i);
      be = 4'(i * 5 + 1);
      irdyN = 1'b0; frameN = (i == n - 1); adIn = d; cbeN = be;
      #0.5;
      if (cyc == 1) check(devselN == 1'b1, "R2 devsel not yet", devselN, 1);
      if (cyc == 2) check(devselN == 1'b0, "R2 devsel medium", devselN, 0);
      if (releaseCyc > 11 && cyc == 11) check(trdyN == 1'b1, "R6 throttle when full", trdyN, 1);
      if (releaseCyc > 11 && cyc == releaseCyc + 1) check(trdyN == 1'b0, "R6 resume after pop", trdyN, 0);
      if (!trdyN) begin
        if (firstTrdy < 0) firstTrdy = cyc;
        sbQueue.push_back({({addr[31:2], 2'b00} + 32'(4 * i)), d, ~be});
        nPushes++;
        i++;
      end
    end
    check(firstTrdy == 3, "R4 first write trdy", 68'(firstTrdy), 3);
    finishAddr();
  endtask

  task automatic doRead(input logic [31:0] addr, input int n, input logic [3:0] lat,
                        input logic region, input int expL);
    int cyc = 0, i = 0, firstTrdy = -1, guard = 0;
    logic parPend = 1'b0, expPar = 1'b0;
    logic [31:0] expD;
    logic [3:0] be;
    @(negedge clk);
    frameN = 1'b0; irdyN = 1'b1; adIn = addr; cbeN = 4'h6; latIn = lat; regionSel = region;
    while (i < n && guard < 200) begin
      @(negedge clk); cyc++; guard++;
      be = 4'(i * 3 + 2);
      irdyN = 1'b0; frameN = (i == n - 1); adIn = '0; cbeN = be;
      #0.5;
      if (cyc == 2) check(devselN == 1'b0, "R2 read devsel", devselN, 0);
      if (parPend) check(parOe && parOut == expPar, "R9 read parity", {parOe, parOut}, {1'b1, expPar});
      parPend = 1'b0;
      if (!trdyN) begin
        if (firstTrdy < 0) firstTrdy = cyc;
        expD = rdModel({addr[31:2], 2'b00} + 32'(4 * i));
        check(adOe && adOut == expD, "R8 read data", {adOe, adOut}, {1'b1, expD});
        expPar = ^{expD, be};
        parPend = 1'b1;
        i++;
      end
    end
    check(firstTrdy == expL, "R7 read latency", 68'(firstTrdy), 68'(expL));
    @(negedge clk); frameN = 1'b1; irdyN = 1'b1; cbeN = 4'hF;
    #0.5;
    check(parOe && parOut == expPar, "R9 last parity", {parOe, parOut}, {1'b1, expPar});
    check(devselN && trdyN && ctlOe, "R10 read turnaround", {devselN, trdyN, ctlOe}, 3'b111);
    @(negedge clk); #0.5;
    check(!ctlOe && !parOe, "R10 read release", {ctlOe, parOe}, 2'b00);
  endtask

  task automatic doIgnored(input logic [31:0] addr, input logic [3:0] cmd, input string tag);
    @(negedge clk); frameN = 1'b0; irdyN = 1'b1; adIn = addr; cbeN = cmd;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); frameN = 1'b1; irdyN = 1'b0; adIn = 32'hDEAD_0000; cbeN = 4'h0;
      #0.5;
      check(devselN && trdyN && !ctlOe && !drnValid, tag, {devselN, trdyN, ctlOe, drnValid}, 4'b1100);
    end
    @(negedge clk); irdyN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    check(devselN && trdyN && !ctlOe && !adOe && !parOe && !drnValid, "R1 during reset",
          {devselN, trdyN, ctlOe, adOe, parOe, drnValid}, 6'b110000);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); #0.5;
    check(devselN && trdyN && !ctlOe && !drnValid, "R1 after reset",
          {devselN, trdyN, ctlOe, drnValid}, 4'b1100);

    doWrite(BASE + 32'h10, 1, 0);
    doWrite(BASE + 32'h100, 4, 0);
    doIgnored(BASE + 32'h20, 4'h2, "R3 non-memory command");
    doIgnored(BASE + 32'h1000, 4'h7, "R3 outside window");
    doRead(BASE + 32'h40, 1, 4'd10, 1'b0, 10);
    doRead(BASE + 32'h80, 3, 4'd10, 1'b1, 12);
    doRead(BASE + 32'h84, 2, 4'd11, 1'b0, 11);
    doRead(BASE + 32'hC0, 1, 4'd1, 1'b0, 3);
    doWrite(BASE + 32'h200, 10, 14);
    repeat (14) @(negedge clk);
    #0.5;
    check(sbQueue.size() == 0 && nPops == nPushes && !drnValid, "R11 all entries drained",
          68'(nPops), 68'(nPushes));
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=done", 200000);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule